// File: doc/BRIEF.md
# Descriptor Ring Manager

This block keeps the transmit and receive buffer-descriptor rings for a frame engine in one small descriptor table inside the block. The table holds 256 words of 32 bits, which is 128 descriptors of two words each. The first word of a descriptor carries the length, the control bits and the status. The second word carries the buffer pointer. A register, the transmit count, divides the table: transmit descriptors take the low indices, and the receive ring begins at the index that the register holds. A host reads and writes the table and the register through one word-wide port. To clear the table, the host writes zero to each word in turn.

Each ring has its own walker. The walker reads the first word of its current descriptor. If the ready bit is clear, the walker stalls until the host writes the table again. If the ready bit is set, the walker fetches the pointer and shows the pointer, the length and the ring index to a consumer. The consumer reports completion with a byte count and eight status flags. The walker then writes the first word back with ready cleared. This tells the host that the descriptor is finished. The walker pulses its interrupt if the descriptor asked for one. It then moves to the next index, or back to index 0 when the descriptor had its wrap bit set.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset, no ring shows a valid descriptor and no interrupt is high. The transmit count reads back as 64 and every table word reads 0.
- R2: A host read with `host_re` high returns data on `host_rdata` in the following cycle. Addresses 0..255 return table words. Address 256 returns the transmit count in bits 7:0, with zeros above. Any higher address returns 0.
- R3: A descriptor's first word has the length in bits 31:16, ready in bit 15, interrupt request in bit 14 and wrap in bit 13. Its second word is the buffer pointer. A ring that finds ready set raises `*_valid` two cycles later and shows that pointer and length.
- R4: A ring whose current descriptor has ready clear keeps `*_valid` low. It checks the descriptor again after each host write to the table, including a write that lands in the same cycle as the check.
- R5: On completion, the first word is rewritten as {count[15:0], 0, interrupt request, wrap, the old bits 12:8, flags[7:0]}.
- R6: `*_irq` is high for exactly one cycle per completed descriptor whose bit 14 is set. It stays low when bit 14 is clear.
- R7: After a write-back, the ring index becomes 0 if the descriptor had wrap set. Otherwise it becomes index+1, modulo 128.
- R8: Receive descriptor k sits at table words 2·((count+k) mod 128) and the word after it, where count is the transmit count register.
- R9: A host write to address 256 loads the transmit count from bits 7:0. It returns both rings to index 0 and drops any descriptor in progress.
- R10: Table writes are granted in this order: host first, then the transmit write-back, then the receive write-back. A write-back that loses waits in place.
- R11: `*_done` has no effect while `*_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 9 | Host word address (0..255 table, 256 transmit count) |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read strobe |
| tx_valid | output | 1 | Transmit descriptor presented |
| tx_ptr | output | 32 | Transmit buffer pointer |
| tx_len | output | 16 | Transmit length in bytes |
| tx_idx | output | 7 | Transmit ring index |
| tx_done | input | 1 | Transmit consumer finished |
| tx_done_len | input | 16 | Byte count written back for transmit |
| tx_done_flags | input | 8 | Status flags written back for transmit |
| tx_irq | output | 1 | Transmit completion interrupt pulse |
| rx_valid | output | 1 | Receive descriptor presented |
| rx_ptr | output | 32 | Receive buffer pointer |
| rx_len | output | 16 | Receive length field |
| rx_idx | output | 7 | Receive ring index, relative to the ring base |
| rx_done | input | 1 | Receive consumer finished |
| rx_done_len | input | 16 | Received byte count written back |
| rx_done_flags | input | 8 | Status flags written back for receive |
| rx_irq | output | 1 | Receive completion interrupt pulse |

## Verification
Each result has a fixed latency from its stimulus:
- A table write that makes a descriptor ready gives a ring `*_valid` two cycles after the write lands, because of the fetch and the pointer cycles.
- A `*_done` pulse moves the ring to write-back at the next edge. The write-back commits one edge later unless a host write or a higher-priority ring holds it off.
- The interrupt is high in the cycle after that commit.
- A host read returns one edge after its strobe.

A behavioural model in the bench applies the same stimulus at every rising edge, and the outputs are compared at every falling edge. Every result is therefore checked in the cycle it is due. Directed checks also sample these cycles by hand. The contention case checks the transmit interrupt and then the receive interrupt on successive edges.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int NRING    = 2;
  localparam int LEN_W    = 16;
  localparam int FLG_W    = 8;
  localparam int RDY_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int KEEP_W   = WRAP_BIT - FLG_W;

  typedef enum logic [2:0] {
    RS_FETCH = 3'd0,
    RS_PTR   = 3'd1,
    RS_BUSY  = 3'd2,
    RS_WB    = 3'd3,
    RS_STALL = 3'd4
  } ring_state_e;
endpackage

// File: rtl/bd_table.sv
module bd_table #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem_q[raddr[g]];
  end
endmodule

// File: rtl/bd_wr_arb.sv
module bd_wr_arb #(
  parameter int NREQ = 2,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [AW-1:0]           host_addr,
  input  logic [DW-1:0]           host_data,
  input  logic [NREQ-1:0]         req,
  input  logic [NREQ-1:0][AW-1:0] req_addr,
  input  logic [NREQ-1:0][DW-1:0] req_data,
  output logic [NREQ-1:0]         gnt,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_data
);
  always_comb begin
    gnt      = '0;
    mem_we   = host_we;
    mem_addr = host_addr;
    mem_data = host_data;
    if (!host_we) begin
      for (int i = 0; i < NREQ; i++) begin
        if (req[i] && (gnt == '0)) begin
          gnt[i]   = 1'b1;
          mem_we   = 1'b1;
          mem_addr = req_addr[i];
          mem_data = req_data[i];
        end
      end
    end
  end

  // R10: at most one ring wins, and never while the host writes
  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r10_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> (gnt == '0));
  // R5: a ring write-back always clears the ready bit
  a_r5_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> !mem_data[bd_ring_pkg::RDY_BIT]);
endmodule

// File: rtl/bd_ring_fsm.sv
module bd_ring_fsm
  import bd_ring_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               host_poke,
  input  logic [IDX_W-1:0]   base,
  output logic [IDX_W:0]     rd_addr,
  input  logic [DW-1:0]      rd_data,
  output logic               wb_req,
  output logic [IDX_W:0]     wb_addr,
  output logic [DW-1:0]      wb_data,
  input  logic               wb_gnt,
  output logic               valid,
  output logic [DW-1:0]      buf_ptr,
  output logic [LEN_W-1:0]   buf_len,
  output logic [IDX_W-1:0]   idx,
  input  logic               done,
  input  logic [LEN_W-1:0]   done_len,
  input  logic [FLG_W-1:0]   done_flags,
  output logic               irq
);
  ring_state_e        state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [LEN_W-1:0]   len_q, len_d, dlen_q, dlen_d;
  logic [DW-1:0]      ptr_q, ptr_d;
  logic               irqen_q, irqen_d, wrap_q, wrap_d, irq_q, irq_d;
  logic [KEEP_W-1:0]  keep_q, keep_d;
  logic [FLG_W-1:0]   dflg_q, dflg_d;
  logic [IDX_W-1:0]   abs_idx;

  assign abs_idx = base + idx_q;
  assign rd_addr = {abs_idx, state_q == RS_PTR};
  assign wb_addr = {abs_idx, 1'b0};
  assign wb_data = {dlen_q, 1'b0, irqen_q, wrap_q, keep_q, dflg_q};
  assign wb_req  = (state_q == RS_WB) && !restart;
  assign valid   = (state_q == RS_BUSY);
  assign buf_ptr = ptr_q;
  assign buf_len = len_q;
  assign idx     = idx_q;
  assign irq     = irq_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    ptr_d   = ptr_q;
    irqen_d = irqen_q;
    wrap_d  = wrap_q;
    keep_d  = keep_q;
    dlen_d  = dlen_q;
    dflg_d  = dflg_q;
    irq_d   = 1'b0;
    case (state_q)
      RS_FETCH: begin
        if (rd_data[RDY_BIT]) begin
          len_d   = rd_data[DW-1 -: LEN_W];
          irqen_d = rd_data[IRQ_BIT];
          wrap_d  = rd_data[WRAP_BIT];
          keep_d  = rd_data[WRAP_BIT-1:FLG_W];
          state_d = RS_PTR;
        end else if (!host_poke) begin
          state_d = RS_STALL;
        end
      end
      RS_PTR: begin
        ptr_d   = rd_data;
        state_d = RS_BUSY;
      end
      RS_BUSY: begin
        if (done) begin
          dlen_d  = done_len;
          dflg_d  = done_flags;
          state_d = RS_WB;
        end
      end
      RS_WB: begin
        if (wb_gnt) begin
          irq_d   = irqen_q;
          idx_d   = wrap_q ? '0 : idx_q + 1'b1;
          state_d = RS_FETCH;
        end
      end
      RS_STALL: begin
        if (host_poke) state_d = RS_FETCH;
      end
      default: state_d = RS_FETCH;
    endcase
    if (restart) begin
      state_d = RS_FETCH;
      idx_d   = '0;
      irq_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_FETCH;
      idx_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
      irqen_q <= 1'b0;
      wrap_q  <= 1'b0;
      keep_q  <= '0;
      dlen_q  <= '0;
      dflg_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      ptr_q   <= ptr_d;
      irqen_q <= irqen_d;
      wrap_q  <= wrap_d;
      keep_q  <= keep_d;
      dlen_q  <= dlen_d;
      dflg_q  <= dflg_d;
      irq_q   <= irq_d;
    end
  end

  // R6: the interrupt is a single-cycle pulse
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R3: a presented descriptor holds still until completion
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !done && !restart) |=> (valid && $stable(buf_ptr) && $stable(buf_len)));
  // R7: the index steps or wraps after a granted write-back
  a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_gnt && !restart) |=> (idx == ($past(wrap_q) ? '0 : IDX_W'($past(idx) + 1'b1))));
  // R4: a stalled ring stays quiet without a host write
  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_STALL && !host_poke && !restart) |=> !valid);
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
  import bd_ring_pkg::*;
#(
  parameter int NDESC     = 128,
  parameter int TXNUM_RST = 64,
  localparam int WORDS    = 2 * NDESC,
  localparam int AW       = $clog2(WORDS),
  localparam int IDX_W    = AW - 1,
  localparam int HA_W     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   host_addr,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tx_valid,
  output logic [31:0]       tx_ptr,
  output logic [LEN_W-1:0]  tx_len,
  output logic [IDX_W-1:0]  tx_idx,
  input  logic              tx_done,
  input  logic [LEN_W-1:0]  tx_done_len,
  input  logic [FLG_W-1:0]  tx_done_flags,
  output logic              tx_irq,
  output logic              rx_valid,
  output logic [31:0]       rx_ptr,
  output logic [LEN_W-1:0]  rx_len,
  output logic [IDX_W-1:0]  rx_idx,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_done_len,
  input  logic [FLG_W-1:0]  rx_done_flags,
  output logic              rx_irq
);
  localparam int NRD = NRING + 1;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic tab_sel, cfg_sel, tab_we, cfg_we;
  assign tab_sel = !host_addr[HA_W-1];
  assign cfg_sel = (host_addr == HA_W'(WORDS));
  assign tab_we  = host_we && tab_sel;
  assign cfg_we  = host_we && cfg_sel;

  logic [IDX_W:0] txnum_q, txnum_d;
  logic [31:0]    rdata_q, rdata_d;

  logic [NRD-1:0][AW-1:0] t_raddr;
  logic [NRD-1:0][31:0]   t_rdata;
  logic                   m_we;
  logic [AW-1:0]          m_addr;
  logic [31:0]            m_data;

  logic [NRING-1:0]                r_done, r_valid, r_irq, r_wbreq, r_gnt;
  logic [NRING-1:0][LEN_W-1:0]     r_dlen, r_len;
  logic [NRING-1:0][FLG_W-1:0]     r_dflg;
  logic [NRING-1:0][31:0]          r_ptr, r_wbdata;
  logic [NRING-1:0][AW-1:0]        r_rdaddr, r_wbaddr;
  logic [NRING-1:0][IDX_W-1:0]     r_idx, r_base;

  always_comb begin
    txnum_d = txnum_q;
    rdata_d = rdata_q;
    if (cfg_we) txnum_d = host_wdata[IDX_W:0];
    if (host_re) begin
      if (tab_sel)      rdata_d = t_rdata[0];
      else if (cfg_sel) rdata_d = 32'(txnum_q);
      else              rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      txnum_q <= (IDX_W+1)'(TXNUM_RST);
      rdata_q <= '0;
    end else begin
      txnum_q <= txnum_d;
      rdata_q <= rdata_d;
    end
  end
  assign host_rdata = rdata_q;

  assign r_done    = {rx_done, tx_done};
  assign r_dlen[0] = tx_done_len;
  assign r_dlen[1] = rx_done_len;
  assign r_dflg[0] = tx_done_flags;
  assign r_dflg[1] = rx_done_flags;
  assign r_base[0] = '0;
  assign r_base[1] = txnum_q[IDX_W-1:0];
  assign t_raddr[0] = host_addr[AW-1:0];

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    bd_ring_fsm #(.IDX_W(IDX_W), .DW(32)) u_ring (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .restart    (cfg_we),
      .host_poke  (tab_we),
      .base       (r_base[r]),
      .rd_addr    (r_rdaddr[r]),
      .rd_data    (t_rdata[r+1]),
      .wb_req     (r_wbreq[r]),
      .wb_addr    (r_wbaddr[r]),
      .wb_data    (r_wbdata[r]),
      .wb_gnt     (r_gnt[r]),
      .valid      (r_valid[r]),
      .buf_ptr    (r_ptr[r]),
      .buf_len    (r_len[r]),
      .idx        (r_idx[r]),
      .done       (r_done[r]),
      .done_len   (r_dlen[r]),
      .done_flags (r_dflg[r]),
      .irq        (r_irq[r])
    );
    assign t_raddr[r+1] = r_rdaddr[r];
  end

  bd_wr_arb #(.NREQ(NRING), .AW(AW), .DW(32)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .host_we   (tab_we),
    .host_addr (host_addr[AW-1:0]),
    .host_data (host_wdata),
    .req       (r_wbreq),
    .req_addr  (r_wbaddr),
    .req_data  (r_wbdata),
    .gnt       (r_gnt),
    .mem_we    (m_we),
    .mem_addr  (m_addr),
    .mem_data  (m_data)
  );

  bd_table #(.WORDS(WORDS), .DW(32), .NRD(NRD)) u_table (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (m_we),
    .waddr (m_addr),
    .wdata (m_data),
    .raddr (t_raddr),
    .rdata (t_rdata)
  );

  assign tx_valid = r_valid[0];
  assign tx_ptr   = r_ptr[0];
  assign tx_len   = r_len[0];
  assign tx_idx   = r_idx[0];
  assign tx_irq   = r_irq[0];
  assign rx_valid = r_valid[1];
  assign rx_ptr   = r_ptr[1];
  assign rx_len   = r_len[1];
  assign rx_idx   = r_idx[1];
  assign rx_irq   = r_irq[1];

  // R9: a count write restarts both rings at index 0
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cfg_we |=> (!tx_valid && !rx_valid && tx_idx == '0 && rx_idx == '0));
  // R2: the count register reads back what was written
  a_r2_count_read: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (host_re && cfg_sel && !cfg_we) |=> (host_rdata == 32'($past(txnum_q))));
endmodule

// File: tb/bd_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module bd_ring_mgr_tb_top;
  localparam int S_FETCH = 0, S_PTR = 1, S_BUSY = 2, S_WB = 3, S_STALL = 4;

  logic        clk, rst_n;
  logic [8:0]  host_addr;
  logic        host_we, host_re;
  logic [31:0] host_wdata, host_rdata;
  logic        tx_valid, rx_valid, tx_irq, rx_irq;
  logic [31:0] tx_ptr, rx_ptr;
  logic [15:0] tx_len, rx_len;
  logic [6:0]  tx_idx, rx_idx;
  logic        b_done [2];
  logic [15:0] b_dlen [2];
  logic [7:0]  b_dflg [2];

  bd_ring_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_idx(tx_idx),
    .tx_done(b_done[0]), .tx_done_len(b_dlen[0]), .tx_done_flags(b_dflg[0]),
    .tx_irq(tx_irq),
    .rx_valid(rx_valid), .rx_ptr(rx_ptr), .rx_len(rx_len), .rx_idx(rx_idx),
    .rx_done(b_done[1]), .rx_done_len(b_dlen[1]), .rx_done_flags(b_dflg[1]),
    .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int tx_irq_cnt = 0;
  bit cmp_en = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mem_m [256];
  int          txn, rcnt;
  logic [31:0] m_rdata;
  int          st [2], idx [2];
  logic [15:0] mlen [2], dlen [2];
  logic [31:0] mptr [2];
  logic        irqb [2], wrapb [2], mirq [2];
  logic [4:0]  keep [2];
  logic [7:0]  dflg [2];

  function automatic logic [31:0] wbw(int r);
    return {dlen[r], 1'b0, irqb[r], wrapb[r], keep[r], dflg[r]};
  endfunction

  task automatic mreset();
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    txn = 64; m_rdata = '0;
    for (int r = 0; r < 2; r++) begin
      st[r] = S_FETCH; idx[r] = 0; mirq[r] = 1'b0; mptr[r] = '0; mlen[r] = '0;
      irqb[r] = 1'b0; wrapb[r] = 1'b0; keep[r] = '0; dlen[r] = '0; dflg[r] = '0;
    end
  endtask

  task automatic mstep();
    int a, absd [2];
    bit htab, hcfg, req0;
    bit g [2];
    logic [31:0] rdw [2];
    a = int'(host_addr);
    htab = host_we && (a < 256);
    hcfg = host_we && (a == 256);
    for (int r = 0; r < 2; r++) begin
      absd[r] = (((r == 0) ? 0 : txn) + idx[r]) % 128;
      rdw[r]  = mem_m[2 * absd[r] + ((st[r] == S_PTR) ? 1 : 0)];
    end
    req0 = (st[0] == S_WB) && !hcfg;
    g[0] = req0 && !htab;
    g[1] = (st[1] == S_WB) && !hcfg && !htab && !req0;
    if (host_re) m_rdata = (a < 256) ? mem_m[a] : ((a == 256) ? 32'(txn) : 32'h0);
    for (int r = 0; r < 2; r++) mirq[r] = g[r] && irqb[r];
    if (htab)      mem_m[a] = host_wdata;
    else if (g[0]) mem_m[2 * absd[0]] = wbw(0);
    else if (g[1]) mem_m[2 * absd[1]] = wbw(1);
    for (int r = 0; r < 2; r++) begin
      case (st[r])
        S_FETCH: if (rdw[r][15]) begin
                   mlen[r] = rdw[r][31:16]; irqb[r] = rdw[r][14];
                   wrapb[r] = rdw[r][13]; keep[r] = rdw[r][12:8]; st[r] = S_PTR;
                 end else if (!htab) st[r] = S_STALL;
        S_PTR:   begin mptr[r] = rdw[r]; st[r] = S_BUSY; end
        S_BUSY:  if (b_done[r]) begin
                   dlen[r] = b_dlen[r]; dflg[r] = b_dflg[r]; st[r] = S_WB;
                 end
        S_WB:    if (g[r]) begin
                   idx[r] = wrapb[r] ? 0 : (idx[r] + 1) % 128; st[r] = S_FETCH;
                 end
        default: if (htab) st[r] = S_FETCH;
      endcase
    end
    if (hcfg) begin
      txn = int'(host_wdata[7:0]);
      for (int r = 0; r < 2; r++) begin st[r] = S_FETCH; idx[r] = 0; mirq[r] = 1'b0; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rcnt = 0; mreset(); end
    else if (rcnt < 2) rcnt++;
    else mstep();
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R3 tx_valid", 32'(tx_valid), 32'(st[0] == S_BUSY));
      check("R8 rx_valid", 32'(rx_valid), 32'(st[1] == S_BUSY));
      if (tx_valid) begin
        check("R3 tx_ptr", tx_ptr, mptr[0]);
        check("R3 tx_len", 32'(tx_len), 32'(mlen[0]));
      end
      if (rx_valid) begin
        check("R8 rx_ptr", rx_ptr, mptr[1]);
        check("R8 rx_len", 32'(rx_len), 32'(mlen[1]));
      end
      check("R7 tx_idx", 32'(tx_idx), 32'(idx[0]));
      check("R7 rx_idx", 32'(rx_idx), 32'(idx[1]));
      check("R6 tx_irq", 32'(tx_irq), 32'(mirq[0]));
      check("R6 rx_irq", 32'(rx_irq), 32'(mirq[1]));
      check("R2 host_rdata", host_rdata, m_rdata);
      if (tx_irq) tx_irq_cnt++;
    end
  end

  task automatic hwr(int a, logic [31:0] d);
    @(negedge clk);
    host_addr = 9'(a); host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 9'(a); host_re = 1'b1;
    @(negedge clk);
    d = host_rdata; host_re = 1'b0;
  endtask

  task automatic pulse_done(int r, logic [15:0] l, logic [7:0] f);
    @(negedge clk);
    b_done[r] = 1'b1; b_dlen[r] = l; b_dflg[r] = f;
    @(negedge clk);
    b_done[r] = 1'b0;
  endtask

  task automatic wait_valid(int r);
    for (int i = 0; i < 40; i++) begin
      if ((r == 0) ? tx_valid : rx_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; host_addr = '0; host_we = 1'b0; host_re = 1'b0; host_wdata = '0;
    for (int r = 0; r < 2; r++) begin b_done[r] = 1'b0; b_dlen[r] = '0; b_dflg[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 tx_valid", 32'(tx_valid), 32'h0);
    check("R1 rx_valid", 32'(rx_valid), 32'h0);
    check("R1 irq", 32'(tx_irq | rx_irq), 32'h0);
    hrd(256, rd); check("R1 count", rd, 32'd64);
    hrd(5, rd);   check("R1 table", rd, 32'h0);
    hrd(300, rd); check("R2 unmapped", rd, 32'h0);

    // R3/R5/R6/R7: transmit descriptor 0 with interrupt, kept bits 12:8 = 0x13
    hwr(1, 32'h0000_1000);
    hwr(0, 32'h0064_D300);
    wait_valid(0);
    check("R3 tx ptr", tx_ptr, 32'h0000_1000);
    check("R3 tx len", 32'(tx_len), 32'd100);
    repeat (3) @(negedge clk);
    check("R3 tx held", 32'(tx_valid), 32'h1);
    pulse_done(0, 16'h0055, 8'hA5);
    repeat (3) @(negedge clk);
    hrd(0, rd); check("R5 writeback", rd, 32'h0055_53A5);
    check("R6 irq count", 32'(tx_irq_cnt), 32'd1);
    check("R7 tx idx step", 32'(tx_idx), 32'd1);

    // R6/R7: descriptor 1 with wrap and no interrupt
    hwr(3, 32'h0000_2000);
    hwr(2, 32'h0040_A000);
    wait_valid(0);
    pulse_done(0, 16'h0040, 8'h00);
    repeat (3) @(negedge clk);
    check("R6 no irq", 32'(tx_irq_cnt), 32'd1);
    check("R7 tx wrap", 32'(tx_idx), 32'd0);
    hrd(2, rd); check("R5 writeback wrap", rd, 32'h0040_2000);

    // R4: stalled ring rechecks after an unrelated write and stays idle
    hwr(200, 32'h0000_1234);
    repeat (5) @(negedge clk);
    check("R4 still stalled", 32'(tx_valid), 32'h0);
    // R11: done ignored while idle
    pulse_done(0, 16'hBEEF, 8'hFF);
    repeat (2) @(negedge clk);
    hrd(0, rd); check("R11 unchanged", rd, 32'h0055_53A5);
    hwr(0, 32'h0010_C000);
    wait_valid(0);
    check("R4 wakes", 32'(tx_valid), 32'h1);

    // R9: count write restarts both rings
    hwr(256, 32'h0000_0004);
    check("R9 tx dropped", 32'(tx_valid), 32'h0);
    check("R9 tx idx", 32'(tx_idx), 32'h0);
    hrd(256, rd); check("R2 count", rd, 32'd4);

    // R8: receive descriptor 0 sits at words 8 and 9
    hwr(9, 32'h2000_0000);
    hwr(8, 32'h0000_C000);
    wait_valid(1);
    wait_valid(0);
    check("R8 rx ptr", rx_ptr, 32'h2000_0000);
    check("R8 rx idx", 32'(rx_idx), 32'h0);

    // R10: both complete together while the host writes
    @(negedge clk);
    b_done[0] = 1'b1; b_dlen[0] = 16'h0011; b_dflg[0] = 8'h01;
    b_done[1] = 1'b1; b_dlen[1] = 16'h0022; b_dflg[1] = 8'h02;
    @(negedge clk);
    b_done[0] = 1'b0; b_done[1] = 1'b0;
    host_addr = 9'd100; host_wdata = 32'h0000_0077; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    check("R10 host first tx", 32'(tx_irq), 32'h0);
    check("R10 host first rx", 32'(rx_irq), 32'h0);
    @(negedge clk);
    check("R10 tx second", 32'(tx_irq), 32'h1);
    check("R10 rx waits", 32'(rx_irq), 32'h0);
    @(negedge clk);
    check("R10 rx third", 32'(rx_irq), 32'h1);
    hrd(0, rd);   check("R5 tx word", rd, 32'h0011_4001);
    hrd(8, rd);   check("R8 rx word", rd, 32'h0022_4002);
    hrd(100, rd); check("R10 host word", rd, 32'h0000_0077);
    check("R7 rx idx", 32'(rx_idx), 32'd1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule